// File: doc/BRIEF.md
# Clock-synchronous serial I/O unit

This block moves bytes between a host and a serial peer over a three-wire clocked link (shift clock, data out, data in) plus a ready strobe. Each direction has its own 8-bit shift path. A one-byte holding register feeds the transmit shifter, and a one-byte register keeps the last received byte. The shift clock comes from one of two places. In the first, the block generates it from the system clock with a programmable half-period, produces one burst of eight cycles per byte and then stops. In the second, an external master drives it on a pin. That pin is resynchronised to the system clock, and the block follows every edge it sees.

The host controls the block through level inputs (transmit enable, receive enable, ready-strobe enable, clock source, divider) and single-cycle strobes (buffer write, receive read, request clears). It observes two transmit flags: holding register empty, and shift finished. It receives two interrupt lines, one for transmit and one for receive. Each line has its own enable, and the transmit line can follow either transmit flag.

Top module: `sio_sync_unit`

## Requirements
- R1: With the internal clock, each loaded byte produces exactly 8 low pulses on `sclk_out`. Each phase lasts `div_val`+1 system cycles. `sclk_out` then rests high until the next byte is loaded.
- R2: Bits leave on `sdo` least significant first and change after each falling shift-clock edge. `sdi` is sampled on each rising edge. The first sampled bit becomes bit 0 of the received byte.
- R3: With `ext_clk_sel`=1, shifting follows the edges of `sclk_in` after synchronisation. Every 8 rising edges complete a byte, and shifting carries on while edges keep arriving. Each high and low phase of `sclk_in` must last at least MIN_PHASE system cycles.
- R4: A 0-to-1 change of `tx_en` sets both `tx_empty` and `tx_done` to 1. While `tx_en` is 0, both flags read 0 and buffer writes are dropped.
- R5: When the transmit shifter is idle and the holding register is full, the byte moves to the shifter. At that move `tx_empty` goes to 1 and `tx_done` goes to 0. `tx_done` returns to 1 after the 8th bit. A byte written during a transfer waits in the holding register (`tx_empty`=0) and follows once the transfer ends.
- R6: A buffer write is accepted only while the active shift clock is high. A write during the low phase leaves `tx_empty` and the data sent unchanged.
- R7: `tx_irq_sel`=0 takes the transmit request from a rise of `tx_empty`, and `tx_irq_sel`=1 takes it from a rise of `tx_done`. `tx_irq_clr` clears the request. `tx_irq` shows the request only while `tx_irq_en`=1.
- R8: With `rx_en`=1, completing a byte copies it to `rx_data` and sets `rx_full` and the receive request. `rx_rd` clears `rx_full`, and `rx_irq_clr` clears the request. `rx_irq` shows the request only while `rx_irq_en`=1.
- R9: `rdy_out` is 1 only with the external clock selected, with `rx_en`, `tx_en` and `rdy_en` all 1, and with a byte loaded whose first falling edge has not yet come. It drops at that edge.
- R10: After reset, `sclk_out`=1, `sdo`=1, and `tx_empty`, `tx_done`, `rx_full`, `tx_irq`, `rx_irq` and `rdy_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_sel | input | 1 | 1 selects the external shift clock on `sclk_in` |
| div_val | input | DIV_W | Internal clock half-period minus one, in system cycles |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| rdy_en | input | 1 | Ready strobe enable |
| tx_irq_sel | input | 1 | Transmit request source: 0 buffer empty, 1 shift finished |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq_clr | input | 1 | Clears the transmit request |
| rx_irq_clr | input | 1 | Clears the receive request |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive register |
| sclk_in | input | 1 | External shift clock |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Internally generated shift clock, idles high |
| sdo | output | 1 | Serial data out |
| rdy_out | output | 1 | Ready strobe towards the external master |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmit shift finished |
| rx_data | output | DATA_W | Last received byte |
| rx_full | output | 1 | Unread byte in `rx_data` |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench uses 8-bit data, a 4-bit divider field, two synchroniser stages and a minimum external phase of 8 cycles. It ties `sdi` to `sdo` in internal mode and sends all 256 byte values, so every bit pattern is checked both on the line and in the receive register. Divider settings of 1 and 3 make the half-period and the self-stop measurable in a few cycles each. For external mode the bench acts as the master. It clocks bytes in both directions, keeps clocking past a byte boundary, and parks the clock low to test the write gate, the ready strobe and the two interrupt sources.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    TXI_BUF_EMPTY  = 1'b0,
    TXI_SHIFT_DONE = 1'b1
  } txi_src_e;

  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 1;
  localparam int IRQ_N  = 2;
endpackage

// File: rtl/sio_clk_gen.sv
// Shift clock source: internal 8-cycle burst generator or synchronised
// external pin, with edge pulses for the shifter.
module sio_clk_gen #(
  parameter int DIV_W       = 8,
  parameter int BITS        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             start,
  input  logic             sclk_ext,
  output logic             lvl,
  output logic             fall_p,
  output logic             rise_p,
  output logic             sclk_out
);
  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int PH_W  = $clog2(MIN_PHASE + 1);

  // internal burst generator
  logic             running;
  logic [DIV_W-1:0] half_cnt;
  logic [CNT_W-1:0] rise_cnt;
  logic             int_lvl, int_fall, int_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      half_cnt <= '0;
      rise_cnt <= '0;
      int_lvl  <= 1'b1;
      int_fall <= 1'b0;
      int_rise <= 1'b0;
    end else begin
      int_fall <= 1'b0;
      int_rise <= 1'b0;
      if (start && !running) begin
        running  <= 1'b1;
        half_cnt <= '0;
        rise_cnt <= '0;
        int_lvl  <= 1'b1;
      end else if (running) begin
        if (half_cnt == div_val) begin
          half_cnt <= '0;
          int_lvl  <= ~int_lvl;
          if (int_lvl) begin
            int_fall <= 1'b1;
          end else begin
            int_rise <= 1'b1;
            if (rise_cnt == CNT_W'(BITS - 1)) running <= 1'b0;
            else rise_cnt <= rise_cnt + 1'b1;
          end
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

  // external pin synchroniser and edge detect
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   ext_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '1;
      ext_prev <= 1'b1;
    end else begin
      sync_q[0] <= sclk_ext;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      ext_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign lvl      = ext_sel ? ext_lvl : int_lvl;
  assign fall_p   = ext_sel ? (ext_prev & ~ext_lvl) : int_fall;
  assign rise_p   = ext_sel ? (~ext_prev & ext_lvl) : int_rise;
  assign sclk_out = int_lvl;

  // phase length tracker for the external pin
  logic [PH_W-1:0] ph_cnt;
  always_ff @(posedge clk) begin
    if (rst) ph_cnt <= PH_W'(MIN_PHASE);
    else if (ext_prev != ext_lvl) ph_cnt <= PH_W'(1);
    else if (ph_cnt < PH_W'(MIN_PHASE)) ph_cnt <= ph_cnt + 1'b1;
  end

  // R1: burst ends by itself with the 8th rising edge
  p_burst_end_r1: assert property (@(posedge clk) disable iff (rst)
    (running && int_lvl == 1'b0 && half_cnt == div_val && rise_cnt == CNT_W'(BITS - 1))
      |=> (!running && int_lvl));

  // R3: external phases respect the minimum width
  p_ext_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_sel && ext_prev != ext_lvl) |-> (ph_cnt >= PH_W'(MIN_PHASE)));
endmodule

// File: rtl/sio_shifter.sv
// Transmit/receive datapath: holding register, shift registers, bit count,
// flags and ready strobe.
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_sel,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              rdy_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              lvl,
  input  logic              fall_p,
  input  logic              rise_p,
  input  logic              sdi,
  output logic              start,
  output logic              sdo,
  output logic              tx_empty,
  output logic              tx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_cplt_p,
  output logic              rdy
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] tx_buf, tx_sr, rx_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              busy, started, tx_en_q;
  logic              act, en_rise, wr_ok, load, cplt;

  assign act     = tx_en | rx_en;
  assign en_rise = tx_en & ~tx_en_q;
  assign wr_ok   = tx_wr & tx_en & tx_en_q & lvl;
  assign load    = tx_en & tx_en_q & ~busy & ~tx_empty;
  assign cplt    = act & rise_p & (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf    <= '0;
      tx_sr     <= '1;
      rx_sr     <= '0;
      rx_data   <= '0;
      bit_cnt   <= '0;
      busy      <= 1'b0;
      started   <= 1'b0;
      tx_en_q   <= 1'b0;
      tx_empty  <= 1'b0;
      tx_done   <= 1'b0;
      rx_full   <= 1'b0;
      rx_cplt_p <= 1'b0;
      start     <= 1'b0;
      sdo       <= 1'b1;
      rdy       <= 1'b0;
    end else begin
      tx_en_q   <= tx_en;
      start     <= 1'b0;
      rx_cplt_p <= 1'b0;

      if (rx_rd) rx_full <= 1'b0;

      // shifting
      if (act && fall_p) begin
        sdo   <= tx_sr[0];
        tx_sr <= {1'b1, tx_sr[DATA_W-1:1]};
        if (busy) started <= 1'b1;
      end
      if (act && rise_p) begin
        rx_sr   <= {sdi, rx_sr[DATA_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (!act) bit_cnt <= '0;
      if (cplt) begin
        if (busy) begin
          busy    <= 1'b0;
          tx_done <= 1'b1;
        end
        if (rx_en) begin
          rx_data   <= {sdi, rx_sr[DATA_W-1:1]};
          rx_full   <= 1'b1;
          rx_cplt_p <= 1'b1;
        end
      end

      // holding register and load
      if (load) begin
        tx_sr    <= tx_buf;
        busy     <= 1'b1;
        started  <= 1'b0;
        tx_done  <= 1'b0;
        tx_empty <= 1'b1;
        start    <= ~ext_sel;
        if (!ext_sel) bit_cnt <= '0;
      end
      if (wr_ok) begin
        tx_buf   <= tx_data;
        tx_empty <= 1'b0;
      end

      // transmitter enable handling has the last word
      if (!tx_en) begin
        tx_empty <= 1'b0;
        tx_done  <= 1'b0;
        busy     <= 1'b0;
        started  <= 1'b0;
      end else if (en_rise) begin
        tx_empty <= 1'b1;
        tx_done  <= 1'b1;
      end

      rdy <= ext_sel & rx_en & tx_en & rdy_en & busy & ~started & ~(act & fall_p);
    end
  end

  // R4: enabling the transmitter raises both flags
  p_en_sets_flags_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |=> (tx_empty && tx_done));

  // R5: a load starts a new shift, so shift-finished drops
  p_load_clears_done_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !tx_done);

  // R6: a write during the low phase leaves an empty buffer empty
  p_wr_low_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !lvl && tx_en && tx_empty) |=> tx_empty);

  // R8: a completed byte with the receiver on marks the register full
  p_rx_full_r8: assert property (@(posedge clk) disable iff (rst)
    (cplt && rx_en) |=> rx_full);

  // R9: ready strobe only under the full enable set in external mode
  p_rdy_gate_r9: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(ext_sel && rx_en && tx_en && rdy_en));
endmodule

// File: rtl/sio_irq_chan.sv
// One interrupt request bit: set on a source rise, cleared by strobe,
// gated by its enable onto a registered output.
module sio_irq_chan (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic clr,
  input  logic en,
  output logic irq
);
  logic src_q, req, set_c;

  assign set_c = src & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      req   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      src_q <= src;
      if (set_c) req <= 1'b1;
      else if (clr) req <= 1'b0;
      irq <= (set_c | (req & ~clr)) & en;
    end
  end

  // R7 (also R8 for the receive channel): output only while enabled
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en));

  // R7: clear without a new rise empties the request
  p_req_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_c) |=> !req);
endmodule

// File: rtl/sio_sync_unit.sv
module sio_sync_unit
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              rdy_en,
  input  logic              tx_irq_sel,
  input  logic              tx_irq_en,
  input  logic              rx_irq_en,
  input  logic              tx_irq_clr,
  input  logic              rx_irq_clr,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              sclk_in,
  input  logic              sdi,
  output logic              sclk_out,
  output logic              sdo,
  output logic              rdy_out,
  output logic              tx_empty,
  output logic              tx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic lvl, fall_p, rise_p, start, rx_cplt_p;

  sio_clk_gen #(
    .DIV_W(DIV_W), .BITS(DATA_W), .SYNC_STAGES(SYNC_STAGES), .MIN_PHASE(MIN_PHASE)
  ) u_clk (
    .clk(clk), .rst(rst), .ext_sel(ext_clk_sel), .div_val(div_val), .start(start),
    .sclk_ext(sclk_in), .lvl(lvl), .fall_p(fall_p), .rise_p(rise_p), .sclk_out(sclk_out)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .ext_sel(ext_clk_sel), .tx_en(tx_en), .rx_en(rx_en),
    .rdy_en(rdy_en), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .lvl(lvl),
    .fall_p(fall_p), .rise_p(rise_p), .sdi(sdi), .start(start), .sdo(sdo),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_data(rx_data), .rx_full(rx_full),
    .rx_cplt_p(rx_cplt_p), .rdy(rdy_out)
  );

  logic [IRQ_N-1:0] irq_src, irq_clr, irq_en, irq_q;

  assign irq_src[IRQ_TX] = (txi_src_e'(tx_irq_sel) == TXI_SHIFT_DONE) ? tx_done : tx_empty;
  assign irq_src[IRQ_RX] = rx_cplt_p;
  assign irq_clr[IRQ_TX] = tx_irq_clr;
  assign irq_clr[IRQ_RX] = rx_irq_clr;
  assign irq_en[IRQ_TX]  = tx_irq_en;
  assign irq_en[IRQ_RX]  = rx_irq_en;

  for (genvar c = 0; c < IRQ_N; c++) begin : g_irq
    sio_irq_chan u_chan (
      .clk(clk), .rst(rst), .src(irq_src[c]), .clr(irq_clr[c]),
      .en(irq_en[c]), .irq(irq_q[c])
    );
  end

  assign tx_irq = irq_q[IRQ_TX];
  assign rx_irq = irq_q[IRQ_RX];
endmodule

// File: tb/sio_sync_unit_tb_top.sv
module sio_sync_unit_tb_top;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_clk_sel = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic tx_en = 1'b0, rx_en = 1'b0, rdy_en = 1'b0;
  logic tx_irq_sel = 1'b0, tx_irq_en = 1'b0, rx_irq_en = 1'b0;
  logic tx_irq_clr = 1'b0, rx_irq_clr = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic sclk_in = 1'b1;
  logic loop_en = 1'b0, sdi_drv = 1'b0;
  logic sdi;
  logic sclk_out, sdo, rdy_out, tx_empty, tx_done, rx_full, tx_irq, rx_irq;
  logic [DATA_W-1:0] rx_data;

  assign sdi = loop_en ? sdo : sdi_drv;

  always #4 clk = ~clk;

  sio_sync_unit #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(2), .MIN_PHASE(8)) dut_i (
    .clk(clk), .rst(rst), .ext_clk_sel(ext_clk_sel), .div_val(div_val),
    .tx_en(tx_en), .rx_en(rx_en), .rdy_en(rdy_en), .tx_irq_sel(tx_irq_sel),
    .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_irq_clr(tx_irq_clr),
    .rx_irq_clr(rx_irq_clr), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .sclk_in(sclk_in), .sdi(sdi), .sclk_out(sclk_out), .sdo(sdo), .rdy_out(rdy_out),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_data(rx_data), .rx_full(rx_full),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int checks = 0;
  int errors = 0;

  // line monitor: counts internal falling edges, last fall-to-fall gap,
  // and collects sdo at each internal rising edge (LSB first)
  int cyc = 0, falls = 0, last_fall = 0, gap = 0;
  logic prev_sclk = 1'b1;
  logic [DATA_W-1:0] cap = '0;
  always @(negedge clk) begin
    if (prev_sclk && !sclk_out) begin
      falls = falls + 1;
      gap = cyc - last_fall;
      last_fall = cyc;
    end
    if (!prev_sclk && sclk_out) cap = {sdo, cap[DATA_W-1:1]};
    prev_sclk = sclk_out;
    cyc = cyc + 1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic write_tx(input logic [DATA_W-1:0] v);
    tx_data = v; tx_wr = 1'b1; step(1); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1; step(1); rx_rd = 1'b0;
  endtask

  task automatic pulse_tx_clr();
    tx_irq_clr = 1'b1; step(1); tx_irq_clr = 1'b0;
  endtask

  task automatic pulse_rx_clr();
    rx_irq_clr = 1'b1; step(1); rx_irq_clr = 1'b0;
  endtask

  task automatic wait_rx(input int limit);
    for (int k = 0; k < limit; k++) begin
      if (rx_full) break;
      step(1);
    end
  endtask

  // bench as external master: 10-cycle phases, data set at low, read before rise
  task automatic ext_byte(input logic [DATA_W-1:0] mosi, output logic [DATA_W-1:0] miso,
                          output logic rdy_mid);
    rdy_mid = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      sclk_in = 1'b0; sdi_drv = mosi[i];
      step(5);
      if (i == 0) rdy_mid = rdy_out;
      step(5);
      miso[i] = sdo;
      sclk_in = 1'b1;
      step(10);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] miso;
    logic rdy_mid;
    int f0;

    step(4); rst = 1'b0; step(2);

    // R10: reset state
    chk("R10", "sclk_out", sclk_out, 1);
    chk("R10", "sdo", sdo, 1);
    chk("R10", "tx_empty", tx_empty, 0);
    chk("R10", "tx_done", tx_done, 0);
    chk("R10", "rx_full", rx_full, 0);
    chk("R10", "irqs", {tx_irq, rx_irq}, 0);
    chk("R10", "rdy_out", rdy_out, 0);

    // R4 / R7: enabling the transmitter raises flags and the empty-source request
    div_val = 4'd1; loop_en = 1'b1; rx_en = 1'b1;
    tx_irq_sel = 1'b0; tx_irq_en = 1'b1;
    tx_en = 1'b1; step(3);
    chk("R4", "tx_empty after enable", tx_empty, 1);
    chk("R4", "tx_done after enable", tx_done, 1);
    chk("R7", "tx_irq after enable", tx_irq, 1);
    pulse_tx_clr(); step(2);
    chk("R7", "tx_irq after clear", tx_irq, 0);
    tx_irq_en = 1'b0;

    // R1 / R2 / R8: loopback sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      f0 = falls;
      write_tx(DATA_W'(v));
      wait_rx(200);
      chk("R2", "rx_data loopback", rx_data, v);
      chk("R2", "sdo bits LSB first", cap, v);
      chk("R1", "falling edges per byte", falls - f0, 8);
      read_rx();
      chk("R8", "rx_full after read", rx_full, 0);
    end
    f0 = falls; step(30);
    chk("R1", "clock stopped after burst", falls - f0, 0);
    chk("R1", "sclk_out idles high", sclk_out, 1);

    // R8: receive request gating and clear
    chk("R8", "rx_irq gated off", rx_irq, 0);
    rx_irq_en = 1'b1; step(2);
    chk("R8", "rx_irq after enable", rx_irq, 1);
    pulse_rx_clr(); step(2);
    chk("R8", "rx_irq after clear", rx_irq, 0);

    // R1: half-period of div_val+1 = 4 cycles
    div_val = 4'd3;
    write_tx(8'hA5);
    wait_rx(400);
    chk("R1", "fall-to-fall gap", gap, 8);
    chk("R2", "rx_data A5", rx_data, 8'hA5);
    read_rx(); pulse_rx_clr(); step(2);

    // R5: second byte waits in the holding register
    write_tx(8'h3C);
    write_tx(8'hC3);
    chk("R5", "tx_empty with byte waiting", tx_empty, 0);
    chk("R5", "tx_done during shift", tx_done, 0);
    wait_rx(400);
    chk("R5", "first byte received", rx_data, 8'h3C);
    read_rx(); step(2);
    chk("R5", "tx_empty after second load", tx_empty, 1);
    chk("R5", "tx_done during second shift", tx_done, 0);
    wait_rx(400);
    chk("R5", "second byte received", rx_data, 8'hC3);
    chk("R5", "tx_done after 8th bit", tx_done, 1);
    step(2);
    chk("R8", "rx_irq on completion", rx_irq, 1);
    read_rx(); pulse_rx_clr(); rx_irq_en = 1'b0;

    // R7: shift-finished source
    tx_irq_sel = 1'b1; pulse_tx_clr(); tx_irq_en = 1'b1; step(2);
    chk("R7", "tx_irq idle with done source", tx_irq, 0);
    write_tx(8'h5A); step(3);
    chk("R7", "tx_irq quiet while shifting", tx_irq, 0);
    wait_rx(400); step(3);
    chk("R7", "tx_irq on shift finished", tx_irq, 1);
    read_rx(); pulse_tx_clr();
    // R7: empty source fires at the load, before the shift ends
    tx_irq_sel = 1'b0; step(2);
    write_tx(8'h0F); step(3);
    chk("R7", "tx_irq on buffer empty", tx_irq, 1);
    chk("R7", "still shifting", tx_done, 0);
    wait_rx(400); read_rx(); pulse_tx_clr(); tx_irq_en = 1'b0;

    // R6: write during internal low phase is dropped
    write_tx(8'h81);
    for (int k = 0; k < 50; k++) begin
      if (!sclk_out) break;
      step(1);
    end
    write_tx(8'hFF); step(1);
    chk("R6", "tx_empty after low-phase write", tx_empty, 1);
    wait_rx(400);
    chk("R6", "byte sent unchanged", rx_data, 8'h81);
    read_rx();
    f0 = falls; step(40);
    chk("R6", "no extra transfer", falls - f0, 0);

    // external clock mode
    ext_clk_sel = 1'b1; loop_en = 1'b0;
    tx_en = 1'b0; rx_en = 1'b0; step(2);
    chk("R4", "tx_empty while disabled", tx_empty, 0);
    chk("R4", "tx_done while disabled", tx_done, 0);
    tx_en = 1'b1; rx_en = 1'b1; rdy_en = 1'b1; step(3);

    write_tx(8'h96); step(4);
    chk("R9", "rdy_out with byte loaded", rdy_out, 1);
    ext_byte(8'h4B, miso, rdy_mid);
    chk("R9", "rdy_out after first fall", rdy_mid, 0);
    chk("R3", "master received", miso, 8'h96);
    chk("R3", "rx_full", rx_full, 1);
    chk("R3", "rx_data", rx_data, 8'h4B);
    chk("R5", "tx_done after ext byte", tx_done, 1);
    read_rx();

    // R3: shifting continues past the byte boundary
    ext_byte(8'hE1, miso, rdy_mid);
    chk("R3", "second ext byte", rx_data, 8'hE1);
    chk("R3", "rx_full second", rx_full, 1);
    read_rx();

    // R9: no strobe without rdy_en
    rdy_en = 1'b0;
    write_tx(8'h11); step(4);
    chk("R9", "rdy_out with rdy_en off", rdy_out, 0);
    ext_byte(8'h22, miso, rdy_mid);
    chk("R3", "master received 11", miso, 8'h11);
    chk("R3", "rx_data 22", rx_data, 8'h22);
    read_rx();

    // R6: write while external clock is low is dropped
    sclk_in = 1'b0; step(12);
    write_tx(8'h77); step(3);
    chk("R6", "tx_empty after ext low write", tx_empty, 1);
    sclk_in = 1'b1; step(12);
    chk("R6", "tx_empty after release", tx_empty, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule